// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds two independent 32-bit timer/counters behind a simple register bus: an address, a write enable, write data and combinational read data. Each timer has three words: a control/status word, a reload word and a read-only count word. A timer can count up or down by one per clock. On reaching its terminal count it either reloads itself and continues, which gives periodic events, or stops. Either way it raises a status flag, and software clears that flag by writing 1 to it.

Software first writes the reload value. It then sets the load bit alone, so the counter copies the reload word. Finally it rewrites the control word with load cleared and the run bit set. A single level interrupt output is raised while any timer has both its status flag and its interrupt enable set. Several control bits are kept only as storage: the mode bit, the generate and capture enables, the PWM enable and the enable-all bit. They read back as written but do not change counting.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every control, reload and count word of both timers reads as zero and `irq` is low.
- R2: Timer 0 decodes control at 0x00, reload at 0x04 and count at 0x08. Timer 1 uses 0x10, 0x14 and 0x18. Any other address reads zero, and a write to it changes no state.
- R3: Control bits 0 to 7, 9 and 10 read back exactly as last written, including the mode bit 0. Bits 31 down to 11 always read zero.
- R4: While control bit 5 (load) is 1, the count word takes the reload word's value on each clock and does not count.
- R5: With bit 7 (run) at 1, bit 5 at 0 and bit 1 (direction) at 0, the count rises by one per clock.
- R6: With bit 7 at 1, bit 5 at 0 and bit 1 at 1, the count falls by one per clock.
- R7: A running timer whose count equals its terminal value (0x00000000 counting down, 0xFFFFFFFF counting up) with bit 4 (auto-reload) at 1 loads the reload word on the next clock and sets status bit 8 on that same clock. Loading 0 and counting up wraps through the full 32-bit range.
- R8: At terminal count with bit 4 at 0, the timer clears its own bit 7, holds the count and sets bit 8.
- R9: Writing 1 to bit 8 clears it and writing 0 leaves it. Writing back the control word just read acknowledges the interrupt and leaves every other control bit unchanged.
- R10: `irq` is high exactly while some timer has bit 8 and bit 6 (interrupt enable) both at 1. It stays high until a write clears the flag or the enable.
- R11: Bits 0, 2, 3, 9 and 10 have no effect on counting, reloading or status.
- R12: The two timers count, reload and flag independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | Combined level interrupt |

## Verification
Read data and `irq` are combinational views of the registers, so they reflect a rising edge within that same clock period. A write to a control or reload word is visible one edge after it is presented. A counter copies the reload word two edges after the write that sets the load bit, and a status flag appears on the edge that performs the reload or stop. The bench drives each bus operation just after a falling edge and compares `bus_rdata` and `irq` one time unit later, before the next rising edge. It compares them against a behavioural model that advances on every rising edge from the same inputs, so every cycle of every scenario is checked at the moment its value is due.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int DATA_W = 32;
    localparam int CTL_W  = 11;
    localparam int STS_BIT = 8;
    // Bits stored from a write (status is write-1-to-clear, handled apart)
    localparam logic [CTL_W-1:0] CTL_WR_MASK = 11'h6FF;

    typedef struct packed {
        logic all_en;   // 10 stored only
        logic pwm_en;   // 9  stored only
        logic sts;      // 8  interrupt status
        logic run;      // 7
        logic ien;      // 6
        logic ld;       // 5
        logic arel;     // 4
        logic cap_en;   // 3  stored only
        logic gen_en;   // 2  stored only
        logic dn;       // 1
        logic mode;     // 0  stored only
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_LD   = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
    } chan_state_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    localparam int CH_W  = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic [NUM_CH-1:0] wr_ctl_o,
    output logic [NUM_CH-1:0] wr_ld_o,
    output logic [CH_W-1:0]   sel_ch_o,
    output dit_pkg::reg_sel_t sel_reg_o
);
    import dit_pkg::*;

    logic [CH_W-1:0] ch;
    logic [1:0]      word;
    logic            hit;

    always_comb begin
        ch   = addr_i[ADDR_W-1:4];
        word = addr_i[3:2];
        hit  = (addr_i[1:0] == 2'b00) && (int'(ch) < NUM_CH) && (word != 2'd3);
        sel_ch_o  = ch;
        sel_reg_o = hit ? reg_sel_t'(word) : SEL_NONE;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign wr_ctl_o[g] = we_i && hit && (ch == CH_W'(g)) && (word == 2'd0);
        assign wr_ld_o[g]  = we_i && hit && (ch == CH_W'(g)) && (word == 2'd1);
    end
endmodule

// File: rtl/dit_channel.sv
module dit_channel
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_i,
    input  logic              wr_ld_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic              irq_o
);
    chan_state_t       st_d, st_q;
    logic [DATA_W-1:0] term;
    logic              tc_hit;

    always_comb begin
        st_d   = st_q;
        tc_hit = 1'b0;
        term   = st_q.ctl.dn ? '0 : '1;

        if (st_q.ctl.ld) begin
            st_d.count = st_q.reload;
        end else if (st_q.ctl.run) begin
            if (st_q.count == term) begin
                tc_hit = 1'b1;
                if (st_q.ctl.arel) st_d.count   = st_q.reload;
                else               st_d.ctl.run = 1'b0;
            end else if (st_q.ctl.dn) begin
                st_d.count = st_q.count - 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end

        if (wr_ctl_i) begin
            st_d.ctl     = ctl_t'(wdata_i[CTL_W-1:0] & CTL_WR_MASK);
            st_d.ctl.sts = st_q.ctl.sts & ~wdata_i[STS_BIT];
        end
        st_d.ctl.sts = st_d.ctl.sts | tc_hit;

        if (wr_ld_i) st_d.reload = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_o    = st_q.ctl;
    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign irq_o    = st_q.ctl.sts & st_q.ctl.ien;

    // R4: load bit copies the reload word on the next clock
    assert_load_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctl.ld |=> (st_q.count == $past(st_q.reload)));

    // R5: up count step
    assert_up_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.run && !st_q.ctl.ld && !st_q.ctl.dn && st_q.count != '1)
        |=> (st_q.count == $past(st_q.count) + 1'b1));

    // R6: down count step
    assert_down_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.run && !st_q.ctl.ld && st_q.ctl.dn && st_q.count != '0)
        |=> (st_q.count == $past(st_q.count) - 1'b1));

    // R7: reload and flag at terminal count
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.run && !st_q.ctl.ld && st_q.ctl.arel &&
         st_q.count == (st_q.ctl.dn ? '0 : '1))
        |=> (st_q.count == $past(st_q.reload) && st_q.ctl.sts));

    // R8: one-shot stop at terminal count
    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl.run && !st_q.ctl.ld && !st_q.ctl.arel && !wr_ctl_i &&
         st_q.count == (st_q.ctl.dn ? '0 : '1))
        |=> (!st_q.ctl.run && st_q.ctl.sts && $stable(st_q.count)));

    // R9: status only falls through a write of 1 to its bit
    assert_sts_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ctl.sts) |-> $past(wr_ctl_i && wdata_i[STS_BIT]));
endmodule

// File: rtl/dit_rdmux.sv
module dit_rdmux
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0][CTL_W-1:0]  ctl_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] reload_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] count_i,
    input  logic [CH_W-1:0]               sel_ch_i,
    input  reg_sel_t                      sel_reg_i,
    output logic [DATA_W-1:0]             rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (sel_reg_i)
            SEL_CTL: rdata_o = {{(DATA_W-CTL_W){1'b0}}, ctl_i[sel_ch_i]};
            SEL_LD:  rdata_o = reload_i[sel_ch_i];
            SEL_CNT: rdata_o = count_i[sel_ch_i];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 5,
    localparam int CH_W  = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NUM_CH-1:0]              wr_ctl, wr_ld, ch_irq;
    logic [CH_W-1:0]                sel_ch;
    reg_sel_t                       sel_reg;
    logic [NUM_CH-1:0][CTL_W-1:0]   ctl_all;
    logic [NUM_CH-1:0][DATA_W-1:0]  reload_all, count_all;

    dit_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wr_ctl_o (wr_ctl),
        .wr_ld_o  (wr_ld),
        .sel_ch_o (sel_ch),
        .sel_reg_o(sel_reg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dit_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctl_i (wr_ctl[g]),
            .wr_ld_i  (wr_ld[g]),
            .wdata_i  (bus_wdata),
            .ctl_o    (ctl_all[g]),
            .reload_o (reload_all[g]),
            .count_o  (count_all[g]),
            .irq_o    (ch_irq[g])
        );
    end

    dit_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rdmux (
        .ctl_i    (ctl_all),
        .reload_i (reload_all),
        .count_i  (count_all),
        .sel_ch_i (sel_ch),
        .sel_reg_i(sel_reg),
        .rdata_o  (bus_rdata)
    );

    assign irq = |ch_irq;

    // R2: at most one register strobe per write
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctl, wr_ld}));

    // R3: unused control bits read as zero
    assert_ctl_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_reg == SEL_CTL) |-> (bus_rdata[DATA_W-1:CTL_W] == '0));

    // R10: level interrupt holds until a write
    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq);
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_ctl [2];
    logic [31:0] m_ld  [2];
    logic [31:0] m_cnt [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_ctl[i] = '0; m_ld[i] = '0; m_cnt[i] = '0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic [31:0] c, nc, ncnt, term;
                logic ev;
                c = m_ctl[i]; nc = c; ncnt = m_cnt[i]; ev = 1'b0;
                term = c[1] ? 32'h0 : 32'hFFFF_FFFF;
                if (c[5]) ncnt = m_ld[i];
                else if (c[7]) begin
                    if (m_cnt[i] == term) begin
                        ev = 1'b1;
                        if (c[4]) ncnt = m_ld[i];
                        else nc[7] = 1'b0;
                    end else ncnt = c[1] ? m_cnt[i] - 1 : m_cnt[i] + 1;
                end
                if (bus_we && bus_addr == 5'(i*16)) begin
                    nc = bus_wdata & 32'h6FF;
                    nc[8] = c[8] & ~bus_wdata[8];
                end
                if (ev) nc[8] = 1'b1;
                if (bus_we && bus_addr == 5'(i*16+4)) m_ld[i] = bus_wdata;
                m_ctl[i] = nc;
                m_cnt[i] = ncnt;
            end
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00: return m_ctl[0];
            5'h04: return m_ld[0];
            5'h08: return m_cnt[0];
            5'h10: return m_ctl[1];
            5'h14: return m_ld[1];
            5'h18: return m_cnt[1];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic mirq();
        return (m_ctl[0][8] & m_ctl[0][6]) | (m_ctl[1][8] & m_ctl[1][6]);
    endfunction

    // One bus cycle: drive after a falling edge, compare before the rising edge
    task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d,
                        input string tag);
        logic [31:0] exp;
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        exp = mread(a);
        checks++;
        if (bus_rdata !== exp || irq !== mirq()) begin
            errors++;
            $display("FAIL %s: addr %h rdata %h irq %b, expected rdata %h irq %b",
                     tag, a, bus_rdata, irq, exp, mirq());
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        step(1'b0, a, 32'h0, tag);
    endtask

    task automatic watch(input int n, input logic [4:0] a, input string tag);
        for (int k = 0; k < n; k++) rd(a, tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word
        rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h08, "R1");
        rd(5'h10, "R1"); rd(5'h14, "R1"); rd(5'h18, "R1");

        // R2: unmapped addresses read zero and ignore writes
        wr(5'h0C, 32'hFFFF_FFFF, "R2"); wr(5'h1C, 32'h1234_5678, "R2");
        wr(5'h02, 32'hFFFF_FFFF, "R2"); wr(5'h12, 32'h0000_00FF, "R2");
        rd(5'h0C, "R2"); rd(5'h1C, "R2"); rd(5'h01, "R2");
        rd(5'h00, "R2"); rd(5'h10, "R2"); rd(5'h14, "R2");

        // R3: readback of stored bits, mode bit exact, upper bits zero
        wr(5'h00, 32'hFFFF_F65D, "R3"); rd(5'h00, "R3");
        wr(5'h00, 32'h0000_0001, "R3"); rd(5'h00, "R3");
        wr(5'h00, 32'h0000_0000, "R3"); rd(5'h00, "R3");

        // R4 then R5: load 100, then count up
        wr(5'h04, 32'd100, "R4"); wr(5'h00, 32'h20, "R4");
        watch(3, 5'h08, "R4");
        wr(5'h04, 32'd7, "R4"); watch(2, 5'h08, "R4");
        wr(5'h04, 32'd100, "R4"); rd(5'h08, "R4");
        wr(5'h00, 32'h80, "R5"); watch(6, 5'h08, "R5");
        wr(5'h00, 32'h00, "R5"); watch(2, 5'h08, "R5");

        // R6, R7, R10: timer 1 periodic down count with interrupt
        wr(5'h14, 32'd5, "R6"); wr(5'h10, 32'h20, "R6"); rd(5'h18, "R6");
        wr(5'h10, 32'hD2, "R6"); watch(5, 5'h18, "R6");
        watch(4, 5'h18, "R7"); watch(3, 5'h10, "R10");

        // R9: write 0 to status keeps it; write-back acknowledges
        wr(5'h10, 32'hD2, "R9"); rd(5'h10, "R9");
        wr(5'h10, mread(5'h10), "R9"); rd(5'h10, "R9");
        watch(8, 5'h10, "R10");
        wr(5'h10, 32'h100, "R9"); watch(3, 5'h18, "R9");

        // R8: timer 0 one-shot down from 3
        wr(5'h04, 32'd3, "R8"); wr(5'h00, 32'h20, "R8"); rd(5'h08, "R8");
        wr(5'h00, 32'h42, "R8"); wr(5'h00, 32'hC2, "R8");
        watch(6, 5'h08, "R8"); rd(5'h00, "R8");

        // R7: up-count wrap from 0xFFFFFFFC with auto-reload
        wr(5'h00, 32'h100, "R7");
        wr(5'h04, 32'hFFFF_FFFC, "R7"); wr(5'h00, 32'h20, "R7"); rd(5'h08, "R7");
        wr(5'h00, 32'h90, "R7"); watch(10, 5'h08, "R7"); rd(5'h00, "R7");

        // R7: reload 0, up count wraps through the full range
        wr(5'h04, 32'h0, "R7"); wr(5'h00, 32'h20, "R7");
        wr(5'h00, 32'h90, "R7"); watch(4, 5'h08, "R7");

        // R11: stored-only bits set on timer 1 up counting
        wr(5'h14, 32'd2, "R11"); wr(5'h10, 32'h120, "R11");
        wr(5'h10, 32'h68D, "R11"); watch(6, 5'h18, "R11"); rd(5'h10, "R11");

        // R12: both timers running, mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [4:0] a;
            logic [31:0] d;
            case ($urandom % 9)
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08;
                3: a = 5'h10; 4: a = 5'h14; 5: a = 5'h18;
                6: a = 5'h0C; 7: a = 5'h1C; default: a = 5'h02;
            endcase
            if (a[3:2] == 2'd1) d = $urandom % 24;
            else if (($urandom % 4) == 0) d = 32'hFFFF_FFF8 | ($urandom % 8);
            else d = $urandom & 32'h7FF;
            step(($urandom % 4) == 0, a, d, "R12");
        end

        finish_run();
    end
endmodule